// File: doc/BRIEF.md
# Water-Filling CTA Allocator

This block splits the thread-block slots of one shared compute unit among up to three co-located kernels. Each kernel has a small profile table. Entry n of that table holds the measured throughput, as an unsigned fixed-point number, when the kernel runs n+1 thread blocks. Software loads the tables through a single write port. It then sets the active kernel count, the per-unit thread-block budget, a per-kernel cap and a loss threshold in percent, and pulses `start`.

The allocator first gives every active kernel one block. It then hands out one more block per clock cycle, always to the eligible kernel whose current table throughput is lowest. This continues until the total reaches the budget or no kernel can grow further.

When it finishes, the block raises `done` for one cycle and publishes the final counts. It also flags `fallback` when some kernel ends far below the best throughput its table shows, which means the kernels should be placed on separate units instead of sharing one.

Top module: `wf_cta_alloc`

## Requirements
- R1: A `start` pulse seen while idle raises `busy` on the next edge and loads a count of 1 for every kernel with index below `num_kernels` (clamped to NK) and 0 for the others.
- R2: Each busy cycle that does not finish adds exactly one block to the eligible kernel with the lowest current throughput. A kernel holding c blocks reads its throughput from table entry c-1, which is written with `wr_kernel`/`wr_idx`.
- R3: When several eligible kernels share the lowest throughput, the one with the smallest index receives the block.
- R4: Allocation stops once the sum of counts is at least `cta_limit`. A budget at or below the number of active kernels therefore adds no block.
- R5: A kernel is eligible only while its count is below its cap, which is its 4-bit field of `cap` (kernel k at bits 4k+3..4k) clamped to the table depth MAXC. When no active kernel is eligible, the run finishes early.
- R6: At finish, `fallback` is 1 if any active kernel has throughput×100 < peak×(100−`thr_pct`), where peak is the largest entry among its first cap entries. A `thr_pct` of 100 or more never sets it. The value holds until the next start.
- R7: `done` is high for exactly one cycle, on the edge after the last grant, with `busy` low. `alloc` and `fallback` then hold until the next accepted start, even across table writes.
- R8: A `start` pulse while `busy` is high is ignored, and the run continues to the same result.
- R9: Synchronous active-high `rst` clears the counts, tables, `busy`, `done` and `fallback`.
- R10: One grant happens per clock. With s grants, `done` is high s+1 edges after the edge that accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an allocation run |
| num_kernels | input | 2 | Active kernel count (1..3) |
| cta_limit | input | 4 | Thread-block budget for the unit |
| cap | input | 12 | Per-kernel block cap, 4 bits each |
| thr_pct | input | 7 | Allowed loss against peak, percent |
| wr_en | input | 1 | Profile table write strobe |
| wr_kernel | input | 2 | Kernel whose table is written |
| wr_idx | input | 3 | Entry index (block count minus one) |
| wr_data | input | 16 | Throughput value |
| alloc | output | 12 | Per-kernel block counts, 4 bits each |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle finish pulse |
| fallback | output | 1 | Sharing loses too much; use separate units |

## Verification
Every output is registered. Counts therefore show the initial load one edge after `start` is accepted and each grant one edge later. `done` and `fallback` appear on the edge after the final grant, so s grants put `done` s+2 falling edges after the falling edge that drove `start`. The bench runs a behavioural model that updates on the same rising edge as the design, and it compares every output on each falling edge. It also counts falling edges from `start` to `done` and probes the first two edges of a run, so a result that arrives one cycle early or late fails.

// File: rtl/wf_cta_alloc.sv
module wf_cta_alloc #(
  parameter int NK   = 3,
  parameter int MAXC = 8,
  parameter int PW   = 16,
  parameter int CW   = $clog2(MAXC + 1),
  parameter int KW   = (NK > 1) ? $clog2(NK) : 1,
  parameter int IW   = (MAXC > 1) ? $clog2(MAXC) : 1,
  parameter int NW   = $clog2(NK + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [NW-1:0]      num_kernels,
  input  logic [CW-1:0]      cta_limit,
  input  logic [NK*CW-1:0]   cap,
  input  logic [6:0]         thr_pct,
  input  logic               wr_en,
  input  logic [KW-1:0]      wr_kernel,
  input  logic [IW-1:0]      wr_idx,
  input  logic [PW-1:0]      wr_data,
  output logic [NK*CW-1:0]   alloc,
  output logic               busy,
  output logic               done,
  output logic               fallback
);
  localparam int TW = $clog2(NK * MAXC + 1);
  localparam int MW = PW + 8;

  logic [PW-1:0] tbl [NK][MAXC];
  logic [CW-1:0] cnt [NK];
  logic [CW-1:0] capc [NK];
  logic [PW-1:0] tput [NK];
  logic [PW-1:0] peak [NK];
  logic [NK-1:0] lossy;
  logic [NW-1:0] nk;
  logic [TW-1:0] total;
  logic [KW-1:0] sel;
  logic [PW-1:0] best;
  logic          found, finish;

  assign nk     = (num_kernels > NW'(NK)) ? NW'(NK) : num_kernels;
  assign finish = (total >= TW'(cta_limit)) || !found;

  always_comb begin
    total = '0;
    sel   = '0;
    best  = '0;
    found = 1'b0;
    for (int i = 0; i < NK; i++) begin
      capc[i] = (cap[i*CW +: CW] > CW'(MAXC)) ? CW'(MAXC) : cap[i*CW +: CW];
      tput[i] = tbl[i][IW'(cnt[i] - CW'(1))];
      peak[i] = '0;
      for (int j = 0; j < MAXC; j++)
        if (j < int'(capc[i]) && tbl[i][j] > peak[i]) peak[i] = tbl[i][j];
      lossy[i] = (i < int'(nk)) && (thr_pct < 7'd100) &&
                 (MW'(tput[i]) * MW'(100) < MW'(peak[i]) * (MW'(100) - MW'(thr_pct)));
      total = total + TW'(cnt[i]);
      if ((i < int'(nk)) && (cnt[i] < capc[i]) && (!found || tput[i] < best)) begin
        found = 1'b1;
        best  = tput[i];
        sel   = KW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NK; i++)
        for (int j = 0; j < MAXC; j++) tbl[i][j] <= '0;
    end else if (wr_en && int'(wr_kernel) < NK) begin
      tbl[wr_kernel][wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      fallback <= 1'b0;
      for (int i = 0; i < NK; i++) cnt[i] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          fallback <= 1'b0;
          for (int i = 0; i < NK; i++) cnt[i] <= (i < int'(nk)) ? CW'(1) : '0;
        end
      end else if (finish) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        fallback <= |lossy;
      end else begin
        cnt[sel] <= cnt[sel] + CW'(1);
      end
    end
  end

  for (genvar g = 0; g < NK; g++) begin : g_out
    assign alloc[g*CW +: CW] = cnt[g];
  end
endmodule

// File: rtl/wf_cta_alloc_chk.sv
module wf_cta_alloc_chk #(
  parameter int NK = 3,
  parameter int CW = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [NK*CW-1:0] alloc
);
  int sum;
  always_comb begin
    sum = 0;
    for (int i = 0; i < NK; i++) sum = sum + int'(alloc[i*CW +: CW]);
  end

  AST_START_LOADS:    assert property (@(posedge clk) disable iff (rst) (!busy && start) |=> busy);                 // R1
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done);                             // R7
  AST_DONE_IDLE:      assert property (@(posedge clk) disable iff (rst) done |-> !busy);                            // R7
  AST_IDLE_HOLD:      assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> $stable(alloc));      // R7
  AST_NO_SHRINK:      assert property (@(posedge clk) disable iff (rst) busy |=> sum >= $past(sum));                // R8
  AST_STEP_ONE:       assert property (@(posedge clk) disable iff (rst) busy |=> sum <= $past(sum) + 1);            // R10
endmodule

bind wf_cta_alloc wf_cta_alloc_chk #(.NK(NK), .CW(CW)) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .alloc(alloc)
);

// File: tb/wf_cta_alloc_tb_top.sv
`timescale 1ns/1ps
module wf_cta_alloc_tb_top;
  logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0]  num_kernels = 2'd3;
  logic [3:0]  cta_limit = 4'd8;
  logic [11:0] cap = {4'd8, 4'd8, 4'd8};
  logic [6:0]  thr_pct = 7'd60;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_kernel = '0;
  logic [2:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic [11:0] alloc;
  logic        busy, done, fallback;

  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  wf_cta_alloc dut_i (
    .clk(clk), .rst(rst), .start(start), .num_kernels(num_kernels), .cta_limit(cta_limit),
    .cap(cap), .thr_pct(thr_pct), .wr_en(wr_en), .wr_kernel(wr_kernel), .wr_idx(wr_idx),
    .wr_data(wr_data), .alloc(alloc), .busy(busy), .done(done), .fallback(fallback)
  );

  int m_tbl [3][8];
  int m_cnt [3];
  bit m_busy, m_done, m_fb;
  int nk_i, tot, s, bestv, capv, pk, tp;
  bit fnd;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_fb = 0;
      for (int k = 0; k < 3; k++) begin
        m_cnt[k] = 0;
        for (int j = 0; j < 8; j++) m_tbl[k][j] = 0;
      end
    end else begin
      nk_i = (num_kernels > 3) ? 3 : int'(num_kernels);
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_busy = 1; m_fb = 0;
          for (int k = 0; k < 3; k++) m_cnt[k] = (k < nk_i) ? 1 : 0;
        end
      end else begin
        tot = 0; fnd = 0; s = 0; bestv = 0;
        for (int k = 0; k < 3; k++) begin
          capv = (int'(cap[k*4 +: 4]) > 8) ? 8 : int'(cap[k*4 +: 4]);
          tot += m_cnt[k];
          if (k < nk_i && m_cnt[k] < capv && (!fnd || m_tbl[k][m_cnt[k]-1] < bestv)) begin
            fnd = 1; bestv = m_tbl[k][m_cnt[k]-1]; s = k;
          end
        end
        if (tot >= int'(cta_limit) || !fnd) begin
          m_busy = 0; m_done = 1; m_fb = 0;
          for (int k = 0; k < nk_i; k++) begin
            capv = (int'(cap[k*4 +: 4]) > 8) ? 8 : int'(cap[k*4 +: 4]);
            pk = 0;
            for (int j = 0; j < capv; j++) if (m_tbl[k][j] > pk) pk = m_tbl[k][j];
            tp = m_tbl[k][m_cnt[k]-1];
            if (thr_pct < 100 && tp * 100 < pk * (100 - int'(thr_pct))) m_fb = 1;
          end
        end else begin
          m_cnt[s]++;
        end
      end
      if (wr_en && wr_kernel < 3) m_tbl[wr_kernel][wr_idx] = int'(wr_data);
    end
  end

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int a(int k);
    return int'(alloc[k*4 +: 4]);
  endfunction

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      for (int k = 0; k < 3; k++) check("R2 per-clock alloc", a(k), m_cnt[k]);
      check("R7 per-clock done", done, m_done);
      check("R6 per-clock fallback", fallback, m_fb);
      check("R8 per-clock busy", busy, m_busy);
    end
  end

  task automatic load(int k, int v0, int v1, int v2, int v3, int v4, int v5, int v6, int v7);
    int v[8] = '{v0, v1, v2, v3, v4, v5, v6, v7};
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      wr_en = 1; wr_kernel = 2'(k); wr_idx = 3'(j); wr_data = 16'(v[j]);
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic go(output int cyc);
    @(negedge clk);
    start = 1; cyc = 0;
    do begin
      @(negedge clk);
      start = 0;
      cyc++;
    end while (!done && cyc < 200);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R7 watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    @(negedge clk);
    // R9 reset state
    check("R9 alloc", int'(alloc), 0);
    check("R9 busy", busy, 0);
    check("R9 done", done, 0);
    check("R9 fallback", fallback, 0);

    load(0, 10, 20, 30, 30, 30, 30, 30, 30);
    load(1, 50, 50, 50, 50, 50, 50, 50, 50);
    load(2, 15, 25, 30, 30, 30, 30, 30, 30);

    // three kernels, budget 8: probe first edges, then the end
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check("R1 k0 initial", a(0), 1);
    check("R1 k1 initial", a(1), 1);
    check("R1 k2 initial", a(2), 1);
    @(negedge clk);
    check("R2 first grant to lowest", a(0), 2);
    cyc = 2;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    check("R10 done latency (5 grants)", cyc, 7);
    check("R3 tie goes to k0", a(0), 4);
    check("R3 k2 after tie", a(2), 3);
    check("R4 total at budget", a(0) + a(1) + a(2), 8);
    check("R6 no fallback", fallback, 0);
    @(negedge clk);
    check("R7 done one cycle", done, 0);
    load(0, 1, 1, 1, 1, 1, 1, 1, 1);
    repeat (3) @(negedge clk);
    check("R7 alloc held after write", a(0), 4);

    // start while busy
    load(0, 10, 20, 30, 30, 30, 30, 30, 30);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    cyc = 0;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    check("R8 k0 unchanged by extra start", a(0), 4);
    check("R8 k2 unchanged by extra start", a(2), 3);

    // budget at or below active kernels
    cta_limit = 4'd2;
    go(cyc);
    check("R4 no grant latency", cyc, 2);
    check("R4 k1 stays 1", a(1), 1);

    // two kernels, loss beyond threshold
    load(0, 10, 20, 30, 40, 100, 100, 100, 100);
    load(1, 5, 6, 7, 8, 8, 8, 8, 8);
    num_kernels = 2'd2; cta_limit = 4'd4;
    go(cyc);
    check("R1 inactive k2", a(2), 0);
    check("R2 k1 takes grants", a(1), 3);
    check("R6 fallback set", fallback, 1);
    thr_pct = 7'd100;
    go(cyc);
    check("R6 threshold 100 never falls back", fallback, 0);
    thr_pct = 7'd60;

    // caps finish early
    cap = {4'd8, 4'd1, 4'd2}; cta_limit = 4'd8;
    go(cyc);
    check("R5 early finish latency", cyc, 3);
    check("R5 k0 capped", a(0), 2);
    check("R5 k1 capped", a(1), 1);
    cap = {4'd15, 4'd15, 4'd15};
    num_kernels = 2'd3; cta_limit = 4'd15;
    go(cyc);
    check("R5 cap clamp to depth", a(0) + a(1) + a(2), 15);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule